// File: doc/BRIEF.md
# Multi-Queue Cell Bus Inlet

This block gathers fixed-length cells from three local producers and places them on a shared 32-bit cell bus. The three producers are the line side (data cells), the local processor (control cells) and a return path for loopback cells picked up from the bus. Each producer writes whole cells, one word per accepted beat, into a queue of its own. The data queue is deep and the other two hold a single cell each.

While a finished cell is waiting in any queue, the block raises a bus request. An external arbiter answers with a grant. The block then sends one whole cell: 14 consecutive 32-bit words, with a start flag on the first one. When more than one queue is waiting, the loopback queue wins, then control, then data. Loopback cells have their header changed so that they go back to the device that launched them. The header's top byte (bits 31:24) is the destination id and the next byte (bits 23:16) is the origin id. On the way into the loopback queue, the destination takes the old origin value and the origin becomes this device's own id.

Top module: `cell_inlet`

## Requirements
- R1: The data queue holds up to 4 complete cells. `dat_ready` is low while 4 cells are stored and not yet fully sent.
- R2: The control queue and the loopback queue hold one cell each. Their ready output is low while that cell is stored and not yet fully sent.
- R3: `bus_req` is high from the second clock after the last word of a cell is accepted, for as long as any complete cell is waiting.
- R4: A partly written cell causes no request and is never sent.
- R5: A grant starts a transfer only when the block is idle and `bus_req` is high. The first word appears two clocks after the grant edge. A grant with no request has no effect.
- R6: A cell goes out as 14 words on consecutive cycles with `bus_valid` high. `bus_sop` is high on the first word only.
- R7: At grant time, the loopback queue is served before the control queue, and the control queue before the data queue.
- R8: In a loopback cell, word 0 leaves with bits 31:24 set to the received bits 23:16 and bits 23:16 set to `LOCAL_ID`. Bits 15:0 and all other words are unchanged.
- R9: `bus_req` stays high while a cell is on the bus, including its last word. In the next cycle it is low if no complete cell is waiting, and high otherwise.
- R10: Words offered to a full queue are dropped. Stored cells are never overwritten.
- R11: A synchronous reset empties all queues, clears `bus_req` and `bus_valid`, and raises every ready output.
- R12: A grant that arrives during a transfer is ignored.
- R13: Cell words leave in the order they were written. Cells from one queue leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dat_valid | input | 1 | Data cell word offered |
| dat_word | input | 32 | Data cell word |
| dat_ready | output | 1 | Data queue accepts a word |
| ctl_valid | input | 1 | Control cell word offered |
| ctl_word | input | 32 | Control cell word |
| ctl_ready | output | 1 | Control queue accepts a word |
| lpb_valid | input | 1 | Loopback cell word offered |
| lpb_word | input | 32 | Loopback cell word |
| lpb_ready | output | 1 | Loopback queue accepts a word |
| bus_grant | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Bus access request |
| bus_valid | output | 1 | Bus word valid |
| bus_sop | output | 1 | First word of a cell |
| bus_word | output | 32 | Bus data word |

## Verification
The bound checker watches the bus framing on every cycle. It checks that a start flag occurs only at a cell boundary, that a started cell has no gaps until its fourteenth word, and that each transfer traces back to a grant two cycles earlier. It also checks that the request covers every word on the bus and that reset leaves the bus quiet with all queues ready. Some behaviours can only be shown by the bench's scenarios, because they depend on the cells that were written earlier. These are queue capacity, dropped writes to a full queue, the priority order, the loopback header rewrite, word order, and a request level that depends on what remains queued.

// File: rtl/cell_inlet_pkg.sv
package cell_inlet_pkg;

  // Queue indices; a higher index has higher service priority.
  localparam int QI_DAT = 0;
  localparam int QI_CTL = 1;
  localparam int QI_LPB = 2;
  localparam int NUM_Q  = 3;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

endpackage

// File: rtl/cell_queue.sv
module cell_queue #(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int DEPTH      = 4,
  parameter int ID_W       = 8,
  parameter bit REWRITE    = 1'b0,
  parameter logic [ID_W-1:0] LOCAL_ID = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic              wr_ready,
  output logic              has_cell,
  input  logic              claim,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word
);

  localparam int SLOTS = DEPTH * CELL_WORDS;
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int IW    = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [SLOTS];
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [CW-1:0]     used, avail;
  logic              wr_fire, wr_last, rd_last;
  logic [WORD_W-1:0] store_word;

  assign wr_ready = (used < CW'(DEPTH));
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_last  = wr_fire && (wr_idx == IW'(CELL_WORDS - 1));
  assign rd_last  = rd_en && (rd_idx == IW'(CELL_WORDS - 1));
  assign has_cell = (avail != '0);

  generate
    if (REWRITE) begin : g_rewrite
      always_comb begin
        if (wr_idx == '0)
          store_word = {wr_word[WORD_W-ID_W-1 -: ID_W], LOCAL_ID,
                        wr_word[WORD_W-2*ID_W-1:0]};
        else
          store_word = wr_word;
      end
    end else begin : g_pass
      assign store_word = wr_word;
    end
  endgenerate

  // Storage without reset so that it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= store_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      wr_idx  <= '0;
    end else if (wr_fire) begin
      wr_addr <= (wr_addr == AW'(SLOTS - 1)) ? '0 : wr_addr + 1'b1;
      wr_idx  <= wr_last ? '0 : wr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr <= '0;
      rd_idx  <= '0;
    end else if (rd_en) begin
      rd_addr <= (rd_addr == AW'(SLOTS - 1)) ? '0 : rd_addr + 1'b1;
      rd_idx  <= rd_last ? '0 : rd_idx + 1'b1;
    end
  end

  // used: slots holding a complete cell not yet fully read out.
  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0;
    end else begin
      case ({wr_last, rd_last})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  // avail: complete cells not yet claimed by the scheduler.
  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= '0;
    end else begin
      case ({wr_last, claim})
        2'b10:   avail <= avail + 1'b1;
        2'b01:   avail <= avail - 1'b1;
        default: avail <= avail;
      endcase
    end
  end

endmodule

// File: rtl/inlet_scheduler.sv
module inlet_scheduler
  import cell_inlet_pkg::*;
#(
  parameter int CELL_WORDS = 14,
  parameter int NQ         = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NQ-1:0]                 has_cell,
  input  logic                          bus_grant,
  input  logic                          req_now,
  output logic [NQ-1:0]                 claim,
  output logic [NQ-1:0]                 rd_en,
  output logic                          rd_any,
  output logic                          rd_first,
  output logic [$clog2(NQ)-1:0]         rd_src
);

  localparam int SW = $clog2(NQ);
  localparam int IW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;

  tx_state_e     state;
  logic [IW-1:0] idx;
  logic [SW-1:0] cur, pick;
  logic          start;

  // Highest-index queue with a waiting cell wins.
  always_comb begin
    pick = '0;
    for (int i = 0; i < NQ; i++) begin
      if (has_cell[i]) pick = SW'(i);
    end
  end

  assign start    = (state == TX_IDLE) && bus_grant && req_now && (|has_cell);
  assign rd_any   = start || (state == TX_SEND);
  assign rd_first = start;
  assign rd_src   = start ? pick : cur;

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_sel
      assign claim[g] = start && (pick == SW'(g));
      assign rd_en[g] = rd_any && (rd_src == SW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      idx   <= '0;
      cur   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start) begin
            state <= TX_SEND;
            idx   <= IW'(1);
            cur   <= pick;
          end
        end
        TX_SEND: begin
          if (idx == IW'(CELL_WORDS - 1)) begin
            state <= TX_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_port_stage.sv
module bus_port_stage #(
  parameter int WORD_W = 32,
  parameter int NQ     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_any,
  input  logic                       rd_first,
  input  logic [$clog2(NQ)-1:0]      rd_src,
  input  logic [NQ-1:0][WORD_W-1:0]  q_word,
  input  logic                       has_any,
  output logic                       bus_req,
  output logic                       bus_valid,
  output logic                       bus_sop,
  output logic [WORD_W-1:0]          bus_word
);

  localparam int SW = $clog2(NQ);

  logic          q_valid, q_first;
  logic [SW-1:0] q_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      q_first   <= 1'b0;
      q_src     <= '0;
      bus_valid <= 1'b0;
      bus_sop   <= 1'b0;
      bus_word  <= '0;
      bus_req   <= 1'b0;
    end else begin
      q_valid   <= rd_any;
      q_first   <= rd_first;
      q_src     <= rd_src;
      bus_valid <= q_valid;
      bus_sop   <= q_first;
      if (q_valid) bus_word <= q_word[q_src];
      bus_req   <= has_any || rd_any || q_valid;
    end
  end

endmodule

// File: rtl/cell_inlet.sv
module cell_inlet
  import cell_inlet_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int DAT_DEPTH  = 4,
  parameter int CTL_DEPTH  = 1,
  parameter int LPB_DEPTH  = 1,
  parameter int ID_W       = 8,
  parameter logic [ID_W-1:0] LOCAL_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_valid,
  input  logic [WORD_W-1:0] dat_word,
  output logic              dat_ready,
  input  logic              ctl_valid,
  input  logic [WORD_W-1:0] ctl_word,
  output logic              ctl_ready,
  input  logic              lpb_valid,
  input  logic [WORD_W-1:0] lpb_word,
  output logic              lpb_ready,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              bus_valid,
  output logic              bus_sop,
  output logic [WORD_W-1:0] bus_word
);

  localparam int NQ = NUM_Q;
  localparam int SW = $clog2(NQ);

  logic [NQ-1:0]             in_valid, in_ready, has_cell, claim, rd_en;
  logic [NQ-1:0][WORD_W-1:0] in_word, q_word;
  logic                      rd_any, rd_first;
  logic [SW-1:0]             rd_src;

  assign in_valid[QI_DAT] = dat_valid;
  assign in_valid[QI_CTL] = ctl_valid;
  assign in_valid[QI_LPB] = lpb_valid;
  assign in_word[QI_DAT]  = dat_word;
  assign in_word[QI_CTL]  = ctl_word;
  assign in_word[QI_LPB]  = lpb_word;
  assign dat_ready        = in_ready[QI_DAT];
  assign ctl_ready        = in_ready[QI_CTL];
  assign lpb_ready        = in_ready[QI_LPB];

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_q
      localparam int QDEPTH = (i == QI_DAT) ? DAT_DEPTH :
                              (i == QI_CTL) ? CTL_DEPTH : LPB_DEPTH;
      cell_queue #(
        .WORD_W    (WORD_W),
        .CELL_WORDS(CELL_WORDS),
        .DEPTH     (QDEPTH),
        .ID_W      (ID_W),
        .REWRITE   (i == QI_LPB),
        .LOCAL_ID  (LOCAL_ID)
      ) u_queue (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(in_valid[i]),
        .wr_word (in_word[i]),
        .wr_ready(in_ready[i]),
        .has_cell(has_cell[i]),
        .claim   (claim[i]),
        .rd_en   (rd_en[i]),
        .rd_word (q_word[i])
      );
    end
  endgenerate

  inlet_scheduler #(
    .CELL_WORDS(CELL_WORDS),
    .NQ        (NQ)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .has_cell (has_cell),
    .bus_grant(bus_grant),
    .req_now  (bus_req),
    .claim    (claim),
    .rd_en    (rd_en),
    .rd_any   (rd_any),
    .rd_first (rd_first),
    .rd_src   (rd_src)
  );

  bus_port_stage #(
    .WORD_W(WORD_W),
    .NQ    (NQ)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .rd_any   (rd_any),
    .rd_first (rd_first),
    .rd_src   (rd_src),
    .q_word   (q_word),
    .has_any  (|has_cell),
    .bus_req  (bus_req),
    .bus_valid(bus_valid),
    .bus_sop  (bus_sop),
    .bus_word (bus_word)
  );

endmodule

// File: rtl/cell_inlet_chk.sv
module cell_inlet_chk #(
  parameter int CELL_WORDS = 14
) (
  input logic clk,
  input logic rst,
  input logic bus_req,
  input logic bus_grant,
  input logic bus_valid,
  input logic bus_sop,
  input logic dat_ready,
  input logic ctl_ready,
  input logic lpb_ready
);

  localparam int CNW = $clog2(CELL_WORDS + 1);

  logic [CNW-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) beat <= '0;
    else if (bus_valid) beat <= bus_sop ? CNW'(1) : beat + 1'b1;
  end

  AST_SOP_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    bus_sop |-> bus_valid); // R6
  AST_SOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_sop) |-> (beat == '0 || beat == CNW'(CELL_WORDS))); // R6
  AST_MID_CELL_WORD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_sop) |-> (beat != '0 && beat < CNW'(CELL_WORDS))); // R6
  AST_NO_GAP_IN_CELL: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (beat == '0 || beat == CNW'(CELL_WORDS))); // R6
  AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(bus_grant, 2)); // R5
  AST_REQ_COVERS_XFER: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_req); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!bus_req && !bus_valid)); // R11
  AST_RESET_READY: assert property (@(posedge clk)
    rst |=> (dat_ready && ctl_ready && lpb_ready)); // R11

endmodule

bind cell_inlet cell_inlet_chk #(.CELL_WORDS(CELL_WORDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_grant(bus_grant),
  .bus_valid(bus_valid),
  .bus_sop  (bus_sop),
  .dat_ready(dat_ready),
  .ctl_ready(ctl_ready),
  .lpb_ready(lpb_ready)
);

// File: tb/cell_inlet_test.sv
module cell_inlet_test;

  localparam int WW = 32;
  localparam int CW = 14;
  localparam logic [7:0] MY_ID = 8'h5A;
  typedef logic [CW*WW-1:0] cell_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dat_valid = 1'b0, ctl_valid = 1'b0, lpb_valid = 1'b0;
  logic [WW-1:0] dat_word = '0, ctl_word = '0, lpb_word = '0;
  logic dat_ready, ctl_ready, lpb_ready;
  logic bus_grant = 1'b0;
  logic bus_req, bus_valid, bus_sop;
  logic [WW-1:0] bus_word;

  always #5 clk = ~clk;

  cell_inlet #(.LOCAL_ID(MY_ID)) uut (
    .clk(clk), .rst(rst),
    .dat_valid(dat_valid), .dat_word(dat_word), .dat_ready(dat_ready),
    .ctl_valid(ctl_valid), .ctl_word(ctl_word), .ctl_ready(ctl_ready),
    .lpb_valid(lpb_valid), .lpb_word(lpb_word), .lpb_ready(lpb_ready),
    .bus_grant(bus_grant), .bus_req(bus_req), .bus_valid(bus_valid),
    .bus_sop(bus_sop), .bus_word(bus_word)
  );

  int checks = 0;
  int errors = 0;
  cell_t mq_dat[$];
  cell_t mq_ctl[$];
  cell_t mq_lpb[$];

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int qsize(int src);
    case (src)
      0: return mq_dat.size();
      1: return mq_ctl.size();
      default: return mq_lpb.size();
    endcase
  endfunction

  function automatic int qdepth(int src);
    return (src == 0) ? 4 : 1;
  endfunction

  function automatic logic cur_ready(int src);
    case (src)
      0: return dat_ready;
      1: return ctl_ready;
      default: return lpb_ready;
    endcase
  endfunction

  function automatic cell_t loop_fix(cell_t c);
    cell_t r = c;
    r[WW-1:0] = {c[23:16], MY_ID, c[15:0]};
    return r;
  endfunction

  function automatic cell_t rand_cell();
    cell_t c;
    for (int i = 0; i < CW; i++) c[i*WW +: WW] = $urandom;
    return c;
  endfunction

  function automatic bit any_waiting();
    return (mq_dat.size() + mq_ctl.size() + mq_lpb.size()) != 0;
  endfunction

  task automatic drive(int src, logic v, logic [WW-1:0] w);
    case (src)
      0: begin dat_valid = v; dat_word = w; end
      1: begin ctl_valid = v; ctl_word = w; end
      default: begin lpb_valid = v; lpb_word = w; end
    endcase
  endtask

  // Offer words first..last of cell c to queue src.
  task automatic push_words(int src, cell_t c, int first, int last);
    bit acc = 1'b0;
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      begin
        bit expr = qsize(src) < qdepth(src);
        string tag = expr ? ((src == 0) ? "R1" : "R2") : "R10";
        if (i == first) acc = expr;
        chk(cur_ready(src) == expr, tag, "ready", {31'b0, cur_ready(src)}, {31'b0, expr});
      end
      drive(src, 1'b1, c[i*WW +: WW]);
    end
    @(negedge clk);
    drive(src, 1'b0, '0);
    if (acc && last == CW - 1) begin
      case (src)
        0: mq_dat.push_back(c);
        1: mq_ctl.push_back(c);
        default: mq_lpb.push_back(loop_fix(c));
      endcase
    end
  endtask

  task automatic grant_recv(bit pulse_mid);
    bit exp_any;
    int src;
    cell_t exp;
    @(negedge clk);
    exp_any = any_waiting();
    chk(bus_req == exp_any, "R3", "request before grant", {31'b0, bus_req}, {31'b0, exp_any});
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    chk(bus_valid == 1'b0, "R5", "valid one cycle after grant", {31'b0, bus_valid}, 32'd0);
    if (!exp_any) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(bus_valid == 1'b0, "R5", "no transfer without request", {31'b0, bus_valid}, 32'd0);
      end
      return;
    end
    if (mq_lpb.size() != 0) begin src = 2; exp = mq_lpb.pop_front(); end
    else if (mq_ctl.size() != 0) begin src = 1; exp = mq_ctl.pop_front(); end
    else begin src = 0; exp = mq_dat.pop_front(); end
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      bus_grant = (pulse_mid && i == 3);
      chk(bus_valid == 1'b1, "R6", "valid during cell", {31'b0, bus_valid}, 32'd1);
      chk(bus_sop == (i == 0), "R6", "start flag", {31'b0, bus_sop}, {31'b0, (i == 0)});
      chk(bus_word == exp[i*WW +: WW], (src == 2 && i == 0) ? "R8" : "R13",
          $sformatf("word %0d from queue %0d (R7 order)", i, src), bus_word, exp[i*WW +: WW]);
      chk(bus_req == 1'b1, "R9", "request held during cell", {31'b0, bus_req}, 32'd1);
    end
    @(negedge clk);
    bus_grant = 1'b0;
    chk(bus_valid == 1'b0, "R12", "cell ends after 14 words", {31'b0, bus_valid}, 32'd0);
    exp_any = any_waiting();
    chk(bus_req == exp_any, "R9", "request after last word", {31'b0, bus_req}, {31'b0, exp_any});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cell_t c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(bus_req == 1'b0, "R11", "req after reset", {31'b0, bus_req}, 32'd0);
    chk(bus_valid == 1'b0, "R11", "valid after reset", {31'b0, bus_valid}, 32'd0);
    chk({dat_ready, ctl_ready, lpb_ready} == 3'b111, "R11", "readies after reset",
        {29'b0, dat_ready, ctl_ready, lpb_ready}, 32'd7);

    // R5 grant with nothing waiting
    grant_recv(1'b0);

    // R4 partial cell gives no request
    c = rand_cell();
    push_words(0, c, 0, 6);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(bus_req == 1'b0, "R4", "no request for partial cell", {31'b0, bus_req}, 32'd0);
    end
    push_words(0, c, 7, CW - 1);
    grant_recv(1'b0);

    // R1 R2 R10 fill every queue past capacity, then R7 drain in priority order
    for (int k = 0; k < 5; k++) push_words(0, rand_cell(), 0, CW - 1);
    for (int k = 0; k < 2; k++) push_words(1, rand_cell(), 0, CW - 1);
    for (int k = 0; k < 2; k++) push_words(2, rand_cell(), 0, CW - 1);
    grant_recv(1'b1);   // R12 grant pulse mid-transfer
    for (int k = 0; k < 6; k++) grant_recv(k == 2);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int op = int'($urandom % 5);
      if (op < 3) push_words(op, rand_cell(), 0, CW - 1);
      else grant_recv(1'($urandom % 2));
    end
    while (any_waiting()) grant_recv(1'b0);

    // R11 reset with cells queued
    push_words(0, rand_cell(), 0, CW - 1);
    push_words(2, rand_cell(), 0, CW - 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mq_dat.delete();
    mq_ctl.delete();
    mq_lpb.delete();
    @(negedge clk);
    chk(bus_req == 1'b0, "R11", "req after mid-run reset", {31'b0, bus_req}, 32'd0);
    chk({dat_ready, ctl_ready, lpb_ready} == 3'b111, "R11", "readies after mid-run reset",
        {29'b0, dat_ready, ctl_ready, lpb_ready}, 32'd7);
    grant_recv(1'b0);

    finish_run();
  end

endmodule